// File: doc/BRIEF.md
# ADC Output Startup Blanking Unit

This block sits between the sample stream of a decimation filter and a one-word result register with its status flags. Each time the conversion enable goes high, the unit starts a new blanking period. It throws away a programmable number of the first samples that arrive, because a sigma-delta output has not settled yet right after a start. Every later sample is written into the result register. Writing a sample sets a ready flag. The unit also sets an overrun flag when a result that has not been read is replaced. It sets a window flag when a delivered sample falls outside a signed low/high band.

Samples that are thrown away are gone for good. They never reach the result register, they cannot cause an overrun and the window check never sees them. Dropping the enable clears the blanking state at once, so every restart begins a full new blanking period, using the delay value captured at that restart.

Top module: `smp_blank_top`

## Requirements
- R1: After a start with a captured delay of N, the first N accepted samples (`smp_vld` high while `conv_en` is high) are dropped. Sample N+1 is written to `res_data` and sets `rdy_flag` one clock after it is presented.
- R2: A dropped sample leaves `res_data` unchanged.
- R3: The blanking period is applied again on every rising edge of `conv_en`, not only the first one after reset.
- R4: A dropped sample never sets `ovf_flag`.
- R5: A dropped sample never sets `win_flag`.
- R6: With a delay of 0, the first accepted sample after a start is delivered and flagged.
- R7: `skip_cnt` (3 bits, 0 to 7) is captured only in the cycle where `conv_en` rises. Changes to it later in the conversion have no effect.
- R8: A delivered sample that arrives while `rdy_flag` is set, with no `rd_stb` in the same cycle, sets `ovf_flag`. The new sample replaces the old result.
- R9: `rd_stb` clears `rdy_flag` on the next clock, unless a sample is delivered in the same cycle, in which case the flag stays set.
- R10: `ovf_flag` and `win_flag` stay set until `clr_ovf` or `clr_win` respectively is pulsed. If a clear and a new set event fall in the same cycle, the set wins.
- R11: `win_flag` is set when a delivered sample, taken as two's complement, is strictly below `thr_lo` or strictly above `thr_hi`. A sample equal to either threshold does not set it.
- R12: While `conv_en` is low, samples are ignored and the blanking count is cleared.
- R13: After reset, `res_data` is 0 and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_en | input | 1 | Conversion enable; a rising edge starts a blanking period |
| smp_vld | input | 1 | Filter output sample strobe |
| smp_data | input | DW | Filter output sample, two's complement |
| skip_cnt | input | 3 | Number of samples to drop after a start |
| thr_lo | input | DW | Signed lower window threshold |
| thr_hi | input | DW | Signed upper window threshold |
| rd_stb | input | 1 | Result read strobe; clears the ready flag |
| clr_ovf | input | 1 | Clears the overrun flag |
| clr_win | input | 1 | Clears the window flag |
| res_data | output | DW | Last delivered sample |
| rdy_flag | output | 1 | A new result is waiting |
| ovf_flag | output | 1 | Sticky: an unread result was replaced |
| win_flag | output | 1 | Sticky: a delivered sample was outside the window |

## Verification
A blanking count that is wrong in either direction shows up at the first sample after a start. If the count is too high, `rdy_flag` stays low one clock after sample N+1. If it is too low, `res_data` changes one clock after a sample that should have been dropped. A stale count left over from an earlier conversion is caught the same way on the next restart. Errors in the flag logic appear one clock after the delivering sample, as an overrun or window flag that is set or missing. Because those flags are sticky, such an error stays visible until the matching clear input is pulsed.

// File: rtl/smp_blank_pkg.sv
package smp_blank_pkg;
  parameter int SKIP_W = 3;
  typedef logic [SKIP_W-1:0] skip_t;

  // Samples still to drop after this cycle.
  function automatic skip_t skip_next(input logic en, input logic drop, input skip_t remaining);
    if (!en)       return '0;
    else if (drop) return remaining - skip_t'(1);
    else           return remaining;
  endfunction
endpackage

// File: rtl/smp_blank_seq.sv
module smp_blank_seq
  import smp_blank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  conv_en,
  input  logic  smp_vld,
  input  skip_t skip_cnt,
  output logic  start_o,
  output logic  blank_o,
  output logic  deliver_o
);
  logic  en_q;
  skip_t left_q;
  skip_t remaining;
  logic  accept;

  assign start_o   = conv_en & ~en_q;
  assign remaining = start_o ? skip_cnt : left_q;
  assign accept    = conv_en & smp_vld;
  assign blank_o   = accept & (|remaining);
  assign deliver_o = accept & ~(|remaining);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      left_q <= '0;
    end else begin
      en_q   <= conv_en;
      left_q <= skip_next(conv_en, blank_o, remaining);
    end
  end
endmodule

// File: rtl/smp_blank_win.sv
module smp_blank_win #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  output logic          outside
);
  function automatic logic out_of_band(input logic signed [DW-1:0] d,
                                       input logic signed [DW-1:0] l,
                                       input logic signed [DW-1:0] h);
    return (d < l) || (d > h);
  endfunction

  assign outside = out_of_band(data, lo, hi);
endmodule

// File: rtl/smp_blank_res.sv
module smp_blank_res #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deliver,
  input  logic [DW-1:0] data,
  input  logic          outside,
  input  logic          rd_stb,
  input  logic          clr_ovf,
  input  logic          clr_win,
  output logic [DW-1:0] res,
  output logic          rdy,
  output logic          ovf,
  output logic          win
);
  logic overwrite;
  logic win_hit;

  assign overwrite = deliver & rdy & ~rd_stb;
  assign win_hit   = deliver & outside;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0;
      rdy <= 1'b0;
      ovf <= 1'b0;
      win <= 1'b0;
    end else begin
      if (deliver) res <= data;
      rdy <= deliver | (rdy & ~rd_stb);
      ovf <= overwrite | (ovf & ~clr_ovf);
      win <= win_hit | (win & ~clr_win);
    end
  end
endmodule

// File: rtl/smp_blank_top.sv
module smp_blank_top #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_en,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_data,
  input  logic [2:0]    skip_cnt,
  input  logic [DW-1:0] thr_lo,
  input  logic [DW-1:0] thr_hi,
  input  logic          rd_stb,
  input  logic          clr_ovf,
  input  logic          clr_win,
  output logic [DW-1:0] res_data,
  output logic          rdy_flag,
  output logic          ovf_flag,
  output logic          win_flag
);
  logic start_w;
  logic blank_w;
  logic deliver_w;
  logic outside_w;

  smp_blank_seq seq_i (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .smp_vld(smp_vld),
    .skip_cnt(skip_cnt), .start_o(start_w), .blank_o(blank_w), .deliver_o(deliver_w)
  );

  smp_blank_win #(.DW(DW)) win_i (
    .data(smp_data), .lo(thr_lo), .hi(thr_hi), .outside(outside_w)
  );

  smp_blank_res #(.DW(DW)) res_i (
    .clk(clk), .rst_n(rst_n), .deliver(deliver_w), .data(smp_data),
    .outside(outside_w), .rd_stb(rd_stb), .clr_ovf(clr_ovf), .clr_win(clr_win),
    .res(res_data), .rdy(rdy_flag), .ovf(ovf_flag), .win(win_flag)
  );
endmodule

// File: rtl/smp_blank_chk.sv
module smp_blank_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_en,
  input logic          smp_vld,
  input logic [DW-1:0] smp_data,
  input logic          rd_stb,
  input logic          clr_ovf,
  input logic          clr_win,
  input logic [DW-1:0] res_data,
  input logic          rdy_flag,
  input logic          ovf_flag,
  input logic          win_flag,
  input logic          blank_w,
  input logic          deliver_w
);
  always_comb begin
    if (rst_n) a_r1_drop_or_deliver: assert ($onehot0({blank_w, deliver_w}));
  end

  a_r1_deliver_writes: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_w |=> (rdy_flag && res_data == $past(smp_data)));
  a_r2_blank_holds_result: assert property (@(posedge clk) disable iff (!rst_n)
    blank_w |=> $stable(res_data));
  a_r4_no_ovf_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_w && !ovf_flag) |=> !ovf_flag);
  a_r5_no_win_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_w && !win_flag) |=> !win_flag);
  a_r8_overwrite_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver_w && rdy_flag && !rd_stb) |=> ovf_flag);
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !deliver_w) |=> !rdy_flag);
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag);
  a_r10_win_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (win_flag && !clr_win) |=> win_flag);
  a_r12_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |=> ($stable(res_data) && !$rose(rdy_flag)));
endmodule

bind smp_blank_top smp_blank_chk #(.DW(DW)) chk_i (.*);

// File: tb/smp_blank_tb.sv
module smp_blank_top_tb_top;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          conv_en = 1'b0, smp_vld = 1'b0, rd_stb = 1'b0, clr_ovf = 1'b0, clr_win = 1'b0;
  logic [DW-1:0] smp_data = '0, thr_lo = '0, thr_hi = '0;
  logic [2:0]    skip_cnt = '0;
  logic [DW-1:0] res_data;
  logic          rdy_flag, ovf_flag, win_flag;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state: counts samples since the start instead of a down-counter
  bit       m_en = 0, m_rdy = 0, m_ovf = 0, m_win = 0;
  int       m_n = 0, m_seen = 0;
  logic [DW-1:0] m_res = '0;

  always #10 clk = ~clk;

  smp_blank_top #(.DW(DW)) dut_i (.*);

  function automatic bit band_miss(logic [DW-1:0] d, logic [DW-1:0] l, logic [DW-1:0] h);
    int di, li, hi;
    di = $signed(d); li = $signed(l); hi = $signed(h);
    return (di < li) || (di > hi);
  endfunction

  task automatic chk(bit ok, string tag, string act, string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic drive(bit en, bit vld, int data, int skip, bit rd, bit co, bit cw);
    conv_en = en; smp_vld = vld; smp_data = DW'(data); skip_cnt = 3'(skip);
    rd_stb = rd; clr_ovf = co; clr_win = cw;
  endtask

  // Model one clock, then compare all outputs after the edge.
  task automatic step(string tag);
    bit acc, dl;
    if (conv_en && !m_en) begin m_n = skip_cnt; m_seen = 0; end
    if (!conv_en) m_seen = 0;
    acc = conv_en && smp_vld;
    dl  = acc && (m_seen >= m_n);
    if (acc && m_seen < 15) m_seen++;
    m_ovf = (dl && m_rdy && !rd_stb) || (m_ovf && !clr_ovf);
    m_win = (dl && band_miss(smp_data, thr_lo, thr_hi)) || (m_win && !clr_win);
    m_rdy = dl || (m_rdy && !rd_stb);
    if (dl) m_res = smp_data;
    m_en = conv_en;
    @(posedge clk); #2;
    chk(res_data == m_res && rdy_flag == m_rdy && ovf_flag == m_ovf && win_flag == m_win, tag,
        $sformatf("res=%0h rdy=%0b ovf=%0b win=%0b", res_data, rdy_flag, ovf_flag, win_flag),
        $sformatf("res=%0h rdy=%0b ovf=%0b win=%0b", m_res, m_rdy, m_ovf, m_win));
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    thr_lo = DW'(-10); thr_hi = DW'(10);
    repeat (3) @(negedge clk);
    chk(res_data == 0 && !rdy_flag && !ovf_flag && !win_flag, "R13 reset state",
        $sformatf("%0h%0b%0b%0b", res_data, rdy_flag, ovf_flag, win_flag), "0000");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R5: delay 3, blanked samples far outside window
    drive(1, 1, 500, 3, 0, 0, 0); step("R1 R5 blank 1");
    drive(1, 1, -600, 0, 0, 0, 0); step("R7 R5 blank 2 skip change");
    drive(1, 1, 700, 0, 0, 0, 0); step("R2 blank 3");
    chk(!rdy_flag && res_data == 0 && !win_flag, "R2 R5 after blanking",
        $sformatf("rdy=%0b res=%0h win=%0b", rdy_flag, res_data, win_flag), "rdy=0 res=0 win=0");
    drive(1, 1, 5, 0, 0, 0, 0); step("R1 fourth delivered");
    chk(rdy_flag && res_data == 5, "R1 sample N+1",
        $sformatf("rdy=%0b res=%0d", rdy_flag, res_data), "rdy=1 res=5");

    // R12: idle samples ignored; R3/R4 restart with unread result
    drive(0, 1, 99, 0, 0, 0, 0); step("R12 idle 1");
    drive(0, 1, 98, 0, 0, 0, 0); step("R12 idle 2");
    chk(res_data == 5, "R12 idle ignored", $sformatf("%0d", res_data), "5");
    drive(1, 1, 40, 2, 0, 0, 0); step("R3 R4 restart blank 1");
    drive(1, 1, 41, 2, 0, 0, 0); step("R3 R4 restart blank 2");
    chk(!ovf_flag && res_data == 5 && !win_flag, "R4 R3 no overrun while blanking",
        $sformatf("ovf=%0b res=%0d", ovf_flag, res_data), "ovf=0 res=5");
    drive(1, 1, 7, 2, 0, 0, 0); step("R8 overwrite");
    chk(ovf_flag && res_data == 7, "R8 overrun and replace",
        $sformatf("ovf=%0b res=%0d", ovf_flag, res_data), "ovf=1 res=7");

    // R9 R10
    drive(1, 0, 0, 0, 1, 0, 0); step("R9 read");
    chk(!rdy_flag && ovf_flag, "R9 read clears, R10 ovf sticky",
        $sformatf("rdy=%0b ovf=%0b", rdy_flag, ovf_flag), "rdy=0 ovf=1");
    drive(1, 0, 0, 0, 0, 1, 0); step("R10 clear ovf");
    chk(!ovf_flag, "R10 clear ovf", $sformatf("%0b", ovf_flag), "0");

    // R11 boundaries
    drive(1, 1, -10, 0, 1, 0, 0); step("R11 equal low");
    drive(1, 1, 10, 0, 1, 0, 0); step("R11 equal high");
    chk(!win_flag, "R11 thresholds inclusive", $sformatf("%0b", win_flag), "0");
    drive(1, 1, -11, 0, 1, 0, 0); step("R11 below low");
    chk(win_flag && res_data == DW'(-11), "R11 below low sets flag",
        $sformatf("win=%0b", win_flag), "win=1");
    drive(1, 1, 3, 0, 1, 0, 1); step("R10 clear win");
    chk(!win_flag, "R10 clear win", $sformatf("%0b", win_flag), "0");

    // R6: delay 0
    drive(0, 0, 0, 0, 0, 0, 0); step("R12 stop");
    drive(1, 1, 33, 0, 0, 0, 0); step("R6 zero delay");
    chk(rdy_flag && res_data == 33, "R6 first sample delivered",
        $sformatf("rdy=%0b res=%0d", rdy_flag, res_data), "rdy=1 res=33");

    // random phase
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 4000; i++) begin
      bit en;
      en = ($urandom_range(0, 15) == 0) ? !conv_en : conv_en;
      if ($urandom_range(0, 40) == 0) begin
        int a, b;
        a = int'($urandom_range(0, 4000)) - 2000;
        b = a + int'($urandom_range(0, 3000));
        thr_lo = DW'(a); thr_hi = DW'(b);
      end
      drive(en, $urandom_range(0, 1), int'($urandom_range(0, 8000)) - 4000,
            $urandom_range(0, 7), $urandom_range(0, 5) == 0,
            $urandom_range(0, 19) == 0, $urandom_range(0, 19) == 0);
      step("R1 R3 R7 R8 R11 random");
    end
    finish_run();
  end
endmodule